// File: doc/BRIEF.md
# Parallel-Port Byte Receiver with Self-Reload Command

This block takes bytes that a host computer writes to a standard printer-style parallel port and delivers them inside the FPGA. It runs on the board's system clock and never uses the host strobe as a clock. The eight data lines and the strobe line first pass through a chain of synchronising flops. A change on the synchronised strobe counts as one byte. The byte is then latched and shown on `rx_byte_o`, together with a valid pulse that lasts one clock.

The block also watches the synchronised data lines for a reserved command value. When that value is present for enough consecutive cycles, the block drives its active-low unconfigure output low. The output stays low until reset, which lets the host reload the FPGA without a power cycle. The paper-out status line is held at its idle high level. An active-high LED output toggles on every received byte as an activity indicator.

There are two state machines. The capture machine has the states IDLE and ARM. IDLE moves to ARM when a strobe edge is seen. ARM stays in ARM when a further edge is seen and goes back to IDLE otherwise. Each cycle spent in ARM emits one byte on the following edge. The command watcher has the states WATCH and FIRED. WATCH moves to FIRED once the match counter completes. FIRED is left only by reset.

Top module: `lpt_byte_rx`

## Requirements
- R1: While `rst_n` is low and right after it rises, `rx_valid_o`=0, `rx_byte_o`=0, `led_o`=0, `unconf_n_o`=1 and `paper_out_o`=1.
- R2: Each change of `pp_strobe_i` (rise or fall, with the default edge mode) yields exactly one `rx_valid_o` pulse of one clock. During that pulse `rx_byte_o` equals the byte held on `pp_data_i` around the strobe change.
- R3: Take the clock edge that first samples a new strobe level. `rx_valid_o` is high in the cycle after the third clock edge following it, and low in the cycle before that.
- R4: `rx_byte_o` keeps its value in every cycle in which `rx_valid_o` is low.
- R5: `unconf_n_o` goes low when the synchronised data has equalled 8'h55 on CMD_HOLD (default 2) consecutive clocks. A single-cycle 8'h55 on `pp_data_i` leaves it high.
- R6: No data value other than 8'h55, sent with or without a strobe, ever drives `unconf_n_o` low.
- R7: Once low, `unconf_n_o` stays low until reset and is high again after reset. Bytes keep being received while it is low.
- R8: `paper_out_o` is 1 at all times.
- R9: `led_o` toggles in exactly the cycles in which `rx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pp_data_i | input | 8 | Host parallel-port data lines (asynchronous) |
| pp_strobe_i | input | 1 | Host strobe line (asynchronous), one change per byte |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse when a new byte is on `rx_byte_o` |
| unconf_n_o | output | 1 | Active-low self-unconfigure request, sticky until reset |
| paper_out_o | output | 1 | Paper-out status line, held high |
| led_o | output | 1 | Active-high activity LED, toggles per byte |

## Verification
The capture path and the command watcher can act in the same cycle. When the host places 8'h55 on the data lines together with the strobe change, with no setup delay, both paths run through equal register depths. The byte's valid pulse and the fall of `unconf_n_o` therefore land on the same edge. The bench provokes this case and checks, in that single sampled cycle, that `rx_valid_o` is high, that `rx_byte_o` is 8'h55 and that `unconf_n_o` has just fallen. It also checks that `unconf_n_o` was still high one cycle earlier.

// File: rtl/lpt_rx_pkg.sv
package lpt_rx_pkg;

    // Which strobe transitions count as one byte.
    typedef enum logic [1:0] {
        STB_ANY  = 2'd0,
        STB_FALL = 2'd1,
        STB_RISE = 2'd2
    } stb_mode_e;

    // Capture machine states.
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_ARM  = 1'b1
    } rx_state_e;

    // Command watcher states.
    typedef enum logic {
        CW_WATCH = 1'b0,
        CW_FIRED = 1'b1
    } cw_state_e;

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lpt_edge_det.sv
module lpt_edge_det
    import lpt_rx_pkg::*;
#(
    parameter stb_mode_e MODE = STB_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s_i;
    end

    generate
        if (MODE == STB_FALL) begin : g_fall
            assign edge_o = prev_q & ~s_i;
        end else if (MODE == STB_RISE) begin : g_rise
            assign edge_o = ~prev_q & s_i;
        end else begin : g_any
            assign edge_o = prev_q ^ s_i;
        end
    endgenerate
endmodule

// File: rtl/lpt_capture_fsm.sv
module lpt_capture_fsm
    import lpt_rx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] byte_o,
    output logic         valid_o,
    output logic         led_o
);
    rx_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (edge_i) state_d = RX_ARM;
            RX_ARM:  state_d = edge_i ? RX_ARM : RX_IDLE;
        endcase
    end

    // Outputs: the byte is taken one cycle after the edge, giving the
    // data lines an extra synchroniser cycle to settle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
            led_o   <= 1'b0;
        end else begin
            unique case (state_q)
                RX_ARM: begin
                    byte_o  <= data_i;
                    valid_o <= 1'b1;
                    led_o   <= ~led_o;
                end
                RX_IDLE: valid_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lpt_cmd_watch.sv
module lpt_cmd_watch
    import lpt_rx_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] CMD  = 8'h55,
    parameter int           HOLD = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_i,
    output logic         unconf_n_o
);
    localparam int CW = $clog2(HOLD + 1);

    cw_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          hit;
    logic          done;

    assign hit  = (data_i == CMD);
    assign done = hit && (cnt_q == CW'(HOLD - 1));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CW_WATCH;
        else        state_q <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CW_WATCH: if (done) state_d = CW_FIRED;
            CW_FIRED: state_d = CW_FIRED;
        endcase
    end

    // Outputs: match-run counter and registered request line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            unconf_n_o <= 1'b1;
        end else begin
            unique case (state_q)
                CW_WATCH: begin
                    cnt_q <= hit ? cnt_q + CW'(1) : '0;
                    if (done) unconf_n_o <= 1'b0;
                end
                CW_FIRED: begin
                    cnt_q      <= '0;
                    unconf_n_o <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lpt_byte_rx.sv
module lpt_byte_rx
    import lpt_rx_pkg::*;
#(
    parameter int           DATA_W    = 8,
    parameter int           SYNC_LEN  = 2,
    parameter stb_mode_e    STB_MODE  = STB_ANY,
    parameter logic [7:0]   CMD_BYTE  = 8'h55,
    parameter int           CMD_HOLD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pp_data_i,
    input  logic              pp_strobe_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              unconf_n_o,
    output logic              paper_out_o,
    output logic              led_o
);
    logic [DATA_W-1:0] data_s;
    logic              stb_s;
    logic              stb_edge;

    lpt_sync #(.W(DATA_W), .STAGES(SYNC_LEN)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d_i(pp_data_i), .q_o(data_s)
    );

    lpt_sync #(.W(1), .STAGES(SYNC_LEN)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .d_i(pp_strobe_i), .q_o(stb_s)
    );

    lpt_edge_det #(.MODE(STB_MODE)) u_edge (
        .clk(clk), .rst_n(rst_n), .s_i(stb_s), .edge_o(stb_edge)
    );

    lpt_capture_fsm #(.W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .edge_i(stb_edge), .data_i(data_s),
        .byte_o(rx_byte_o), .valid_o(rx_valid_o), .led_o(led_o)
    );

    lpt_cmd_watch #(.W(DATA_W), .CMD(DATA_W'(CMD_BYTE)), .HOLD(CMD_HOLD)) u_cmd (
        .clk(clk), .rst_n(rst_n), .data_i(data_s), .unconf_n_o(unconf_n_o)
    );

    // Idle level required so printer-mode reload keeps working.
    assign paper_out_o = 1'b1;
endmodule

// File: rtl/lpt_byte_rx_chk.sv
module lpt_byte_rx_chk #(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] CMD_BYTE = 8'h55
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] pp_data_i,
    input logic [DATA_W-1:0] rx_byte_o,
    input logic              rx_valid_o,
    input logic              unconf_n_o,
    input logic              led_o
);
    // R4: byte register only moves with a valid pulse.
    p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> $stable(rx_byte_o));

    // R7: request is sticky.
    p_unconf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !unconf_n_o |=> !unconf_n_o);

    // R9: LED toggles with each valid pulse.
    p_led_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (led_o != $past(led_o)));

    // R9: LED quiet without a valid pulse.
    p_led_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> $stable(led_o));

    // R5/R6: a fall needs the command on the port three samples earlier.
    p_unconf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unconf_n_o) |-> ($past(pp_data_i, 3) == DATA_W'(CMD_BYTE)));
endmodule

bind lpt_byte_rx lpt_byte_rx_chk #(.DATA_W(DATA_W), .CMD_BYTE(CMD_BYTE)) chk_i (
    .clk(clk), .rst_n(rst_n), .pp_data_i(pp_data_i), .rx_byte_o(rx_byte_o),
    .rx_valid_o(rx_valid_o), .unconf_n_o(unconf_n_o), .led_o(led_o)
);

// File: tb/lpt_byte_rx_tb_top.sv
module lpt_byte_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pp_data_i = 8'h00;
    logic       pp_strobe_i = 1'b0;
    logic [7:0] rx_byte_o;
    logic       rx_valid_o;
    logic       unconf_n_o;
    logic       paper_out_o;
    logic       led_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    logic       exp_led = 1'b0;
    logic       last_byte = 1'b0;
    logic [7:0] last_val = 8'h00;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    lpt_byte_rx dut_i (
        .clk(clk), .rst_n(rst_n), .pp_data_i(pp_data_i), .pp_strobe_i(pp_strobe_i),
        .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .unconf_n_o(unconf_n_o),
        .paper_out_o(paper_out_o), .led_o(led_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected bytes as the design presents them (R2, R9, R8).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(paper_out_o == 1'b1, "R8 paper-out high", paper_out_o, 1);
            if (rx_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected valid pulse", rx_byte_o, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    exp_led = ~exp_led;
                    chk(rx_byte_o == e, "R2 received byte", rx_byte_o, e);
                    chk(led_o == exp_led, "R9 led toggle", led_o, exp_led);
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        exp_q.delete();
        exp_led = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_valid_o == 1'b0, "R1 valid in reset", rx_valid_o, 0);
        chk(unconf_n_o == 1'b1, "R1 unconf in reset", unconf_n_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_byte_o == 8'h00, "R1 byte after reset", rx_byte_o, 0);
        chk(led_o == 1'b0, "R1 led after reset", led_o, 0);
        chk(paper_out_o == 1'b1, "R1 paper-out after reset", paper_out_o, 1);
    endtask

    // Driver: data first, randomized setup, then one strobe change.
    task automatic send(input logic [7:0] b, input int setup);
        @(negedge clk);
        pp_data_i = b;
        repeat (setup) @(negedge clk);
        pp_strobe_i = ~pp_strobe_i;
        exp_q.push_back(b);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R2 byte delivered", exp_q.size(), 0);
        chk(rx_byte_o == b, "R4 byte held", rx_byte_o, b);
    endtask

    initial begin
        int seen;
        do_reset();

        // Random non-command traffic, both strobe directions.
        for (int i = 0; i < 24; i++) begin
            logic [7:0] b;
            b = 8'($urandom_range(0, 255));
            if (b == 8'h55) b = 8'hAA;
            send(b, $urandom_range(0, 3));
            chk(unconf_n_o == 1'b1, "R6 other value keeps unconf high", unconf_n_o, 1);
        end

        // R3 latency, zero setup.
        @(negedge clk);
        pp_data_i = 8'h3C;
        pp_strobe_i = ~pp_strobe_i;
        exp_q.push_back(8'h3C);
        repeat (3) @(negedge clk);
        chk(rx_valid_o == 1'b0, "R3 valid not early", rx_valid_o, 0);
        @(negedge clk);
        chk(rx_valid_o == 1'b1, "R3 valid on third edge", rx_valid_o, 1);
        @(negedge clk);
        chk(rx_valid_o == 1'b0, "R2 single-cycle pulse", rx_valid_o, 0);
        repeat (4) @(negedge clk);
        chk(rx_byte_o == 8'h3C, "R4 byte held after pulse", rx_byte_o, 8'h3C);

        // R5: one-cycle command glitch is ignored.
        @(negedge clk);
        pp_data_i = 8'h55;
        @(negedge clk);
        pp_data_i = 8'h00;
        repeat (8) @(negedge clk);
        chk(unconf_n_o == 1'b1, "R5 glitch ignored", unconf_n_o, 1);

        // R5 plus same-cycle capture: command sent with its strobe.
        @(negedge clk);
        pp_data_i = 8'h55;
        pp_strobe_i = ~pp_strobe_i;
        exp_q.push_back(8'h55);
        repeat (3) @(negedge clk);
        chk(unconf_n_o == 1'b1, "R5 unconf not early", unconf_n_o, 1);
        @(negedge clk);
        chk(rx_valid_o == 1'b1 && rx_byte_o == 8'h55, "R2 command byte captured",
            {rx_valid_o, rx_byte_o}, {1'b1, 8'h55});
        chk(unconf_n_o == 1'b0, "R5 unconf falls with capture", unconf_n_o, 0);

        // R7: sticky, reception continues.
        send(8'h12, 2);
        send(8'hF0, 1);
        chk(unconf_n_o == 1'b0, "R7 unconf sticky", unconf_n_o, 0);
        do_reset();
        chk(unconf_n_o == 1'b1, "R7 released by reset", unconf_n_o, 1);

        // R6: sweep every other value, with and without strobe.
        seen = 0;
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h55) begin
                if (v % 2 == 0) send(8'(v), $urandom_range(0, 3));
                else begin
                    @(negedge clk);
                    pp_data_i = 8'(v);
                    repeat (4) @(negedge clk);
                end
                if (unconf_n_o != 1'b1) seen++;
            end
        end
        chk(seen == 0, "R6 sweep never lowers unconf", seen, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule